// File: doc/BRIEF.md
# Serial Programming Target Interface

This block is the target side of a wired, bit-serial programming link for a small word-organised store. The store is held in registers, by default twelve words of sixteen bits. A host drives a slow programming clock and a data line. The block samples both through two-flop synchronisers on its own system clock. Edges of the host clock are found from the synchronised level.

Raising `prog_en` with `verify_en` low starts a programming session. The block first clears the whole store and ignores the host for a fixed erase interval. It then takes words bit by bit on falling host-clock edges, writing them to consecutive addresses starting at zero. After each word it runs a write-busy interval. A host that keeps its clock high during that interval sees the data line pulled low while the write is pending. Once the write ends, the line is pulled high until the host lowers its clock. Raising `prog_en` with `verify_en` high starts a read-back session instead, in which the block drives the stored bits out for the host to check.

The controller is a single state machine with six states:
- `ST_IDLE`: no session is open.
- `ST_ERASE`: the store is being cleared.
- `ST_RECV`: the block is shifting in a word.
- `ST_BUSY`: the write-busy interval is running.
- `ST_ACK`: the write has finished and the line is held high.
- `ST_VERIFY`: read-back.

The transitions are:
- IDLE→ERASE when programming is requested.
- IDLE→VERIFY when read-back is requested.
- ERASE→RECV when the erase timer expires.
- RECV→BUSY on a complete, in-range word.
- BUSY→ACK when the busy timer expires with the host clock high.
- BUSY→RECV when the busy timer expires with the host clock low.
- ACK→RECV when the host clock goes low.
- Any state →IDLE when `prog_en` drops.

Top module: `serprog_target`

## Requirements
- R1: After reset, `pdat_oe` and `overflow` are 0 and the store reads back as all zeros.
- R2: When a programming session opens, every word is cleared to zero. For `ERASE_CYC` system cycles no host clock edge is taken as data.
- R3: A word is assembled from `W` data bits sampled on falling edges of the synchronised host clock. The first bit sampled is bit 0 (least significant first).
- R4: The write address starts at word 0 in each session and advances by one after every complete word.
- R5: After each stored word, a busy interval of `BUSY_CYC` system cycles runs. Host clock edges during it are not taken as data.
- R6: While the busy interval runs and the host clock is high, the block drives the data line low (`pdat_oe`=1, `pdat_out`=0). While the host clock is low, it does not drive the line.
- R7: When the busy interval ends with the host clock high, the block drives the line high until the host clock falls and then releases it. If the host clock is low at that point, the line is released at once.
- R8: In the last word (address `WORDS`-1), bit positions that are 0 in `CFG_MASK` are stored and read back as zero. The default mask is 16'h0FFF.
- R9: A word completed when the address has already passed the last word is discarded. It starts no busy interval and sets `overflow`, which stays set until `prog_en` drops.
- R10: A session opened with `verify_en`=1 does not erase. The block drives the stored bits least significant first, starting at word 0. Each bit is stable before the host's rising edge, and the block moves to the next bit on the host's falling edge.
- R11: In read-back, addresses past the last word drive 0.
- R12: When `prog_en` is low, the block returns to idle and releases the data line in the next cycle. `overflow` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_en | input | 1 | Session request, system-clock domain |
| verify_en | input | 1 | Selects read-back instead of programming when a session opens |
| pclk_in | input | 1 | Host programming clock, asynchronous |
| pdat_in | input | 1 | Host data line as seen by the block, asynchronous |
| pdat_out | output | 1 | Value the block drives on the data line |
| pdat_oe | output | 1 | Data line drive enable |
| overflow | output | 1 | Sticky flag: a word arrived past the last address |

## Verification
The bench sends a few clock pulses during the erase window and then checks that word 0 was not shifted. A design that accepts edges while erasing would read back a rotated first word. It polls the busy phase and measures when the line goes high relative to the last falling edge. A busy timer that is short or skipped shows up as an early high; an acknowledge that ends early shows up as a line that is not held high. The bench also checks that the falling edge which ends the acknowledge is not counted as the first bit of the next word, which would corrupt every later word. Further checks cover:
- the masked last word;
- an overflow word that must neither write nor start a busy phase;
- read-back past the end;
- a second session that must erase everything it does not rewrite.

// File: rtl/serprog_pkg.sv
package serprog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERASE,
        ST_RECV,
        ST_BUSY,
        ST_ACK,
        ST_VERIFY
    } prog_state_t;

endpackage

// File: rtl/serprog_sync.sv
module serprog_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[s] <= '0;
                end else if (s == 0) begin
                    pipe[s] <= async_in;
                end else begin
                    pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = pipe[STAGES-1];

endmodule

// File: rtl/serprog_shift.sv
module serprog_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         take,
    input  logic         din,
    output logic         word_vld,
    output logic [W-1:0] word
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic [CW-1:0] cnt;
    logic [W-1:0]  sreg;
    logic [W-1:0]  next_sreg;

    assign next_sreg = {din, sreg[W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            sreg     <= '0;
            word     <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (!en) begin
                cnt <= '0;
            end else if (take) begin
                sreg <= next_sreg;
                if (cnt == CW'(W-1)) begin
                    cnt      <= '0;
                    word     <= next_sreg;
                    word_vld <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R3
    shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> !word_vld);

endmodule

// File: rtl/serprog_target.sv
module serprog_target
    import serprog_pkg::*;
#(
    parameter int           WORDS     = 12,
    parameter int           W         = 16,
    parameter logic [W-1:0] CFG_MASK  = 16'h0FFF,
    parameter int           ERASE_CYC = 500000,
    parameter int           BUSY_CYC  = 6250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_en,
    input  logic verify_en,
    input  logic pclk_in,
    input  logic pdat_in,
    output logic pdat_out,
    output logic pdat_oe,
    output logic overflow
);

    localparam int MAXC = (ERASE_CYC > BUSY_CYC) ? ERASE_CYC : BUSY_CYC;
    localparam int TW   = $clog2(MAXC + 1);
    localparam int AW   = $clog2(WORDS + 1);
    localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int BW   = (W > 1) ? $clog2(W) : 1;

    prog_state_t state, state_nx;

    logic [1:0]    sync_q;
    logic          pclk_s, pdat_s, pclk_d, pclk_fall;
    logic [TW-1:0] tmr;
    logic [AW-1:0] addr;
    logic [IW-1:0] idx;
    logic [BW-1:0] vbit;
    logic          in_range;
    logic          word_vld;
    logic [W-1:0]  word;
    logic [W-1:0]  mem [WORDS];
    logic          erase_done, busy_done;

    serprog_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({pclk_in, pdat_in}),
        .sync_out (sync_q)
    );

    assign pclk_s = sync_q[1];
    assign pdat_s = sync_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pclk_d <= 1'b0;
        else        pclk_d <= pclk_s;
    end

    assign pclk_fall = pclk_d & ~pclk_s;

    serprog_shift #(.W(W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (state == ST_RECV),
        .take     (pclk_fall),
        .din      (pdat_s),
        .word_vld (word_vld),
        .word     (word)
    );

    assign in_range   = (addr < AW'(WORDS));
    assign idx        = addr[IW-1:0];
    assign erase_done = (tmr == TW'(ERASE_CYC - 1));
    assign busy_done  = (tmr == TW'(BUSY_CYC - 1));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (prog_en) state_nx = verify_en ? ST_VERIFY : ST_ERASE;
            ST_ERASE:  if (erase_done) state_nx = ST_RECV;
            ST_RECV:   if (word_vld && in_range) state_nx = ST_BUSY;
            ST_BUSY:   if (busy_done) state_nx = pclk_s ? ST_ACK : ST_RECV;
            ST_ACK:    if (!pclk_s) state_nx = ST_RECV;
            ST_VERIFY: state_nx = ST_VERIFY;
            default:   state_nx = ST_IDLE;
        endcase
        if (!prog_en) state_nx = ST_IDLE;
    end

    // state register, timer, address and store
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tmr      <= '0;
            addr     <= '0;
            vbit     <= '0;
            overflow <= 1'b0;
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else begin
            state <= state_nx;
            tmr   <= (state_nx != state) ? '0 : tmr + 1'b1;
            unique case (state)
                ST_IDLE: begin
                    addr     <= '0;
                    vbit     <= '0;
                    overflow <= 1'b0;
                end
                ST_ERASE: begin
                    for (int i = 0; i < WORDS; i++) mem[i] <= '0;
                end
                ST_RECV: begin
                    if (word_vld) begin
                        if (in_range) begin
                            mem[idx] <= (idx == IW'(WORDS - 1)) ? (word & CFG_MASK) : word;
                            addr     <= addr + 1'b1;
                        end else begin
                            overflow <= 1'b1;
                        end
                    end
                end
                ST_VERIFY: begin
                    if (pclk_fall) begin
                        if (vbit == BW'(W - 1)) begin
                            vbit <= '0;
                            if (in_range) addr <= addr + 1'b1;
                        end else begin
                            vbit <= vbit + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // output logic
    always_comb begin
        pdat_oe  = 1'b0;
        pdat_out = 1'b0;
        unique case (state)
            ST_BUSY: begin
                pdat_oe  = pclk_s;
                pdat_out = 1'b0;
            end
            ST_ACK: begin
                pdat_oe  = 1'b1;
                pdat_out = 1'b1;
            end
            ST_VERIFY: begin
                pdat_oe  = 1'b1;
                pdat_out = in_range ? mem[idx][vbit] : 1'b0;
            end
            default: ;
        endcase
    end

    // R2
    erase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE && prog_en && !erase_done) |=> (state == ST_ERASE));

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && prog_en && !busy_done) |=> (state == ST_BUSY && !word_vld));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECV && prog_en && word_vld && in_range) |=> (addr == $past(addr) + 1'b1));

    // R7
    ack_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && prog_en && busy_done && pclk_s) |=> (pdat_oe && pdat_out));

    // R9
    no_overflow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && prog_en) |=> overflow);

    // R12
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_en) |=> !pdat_oe);

endmodule

// File: tb/serprog_target_bench.sv
module serprog_target_bench;

    localparam int WORDS = 12;
    localparam int W     = 16;
    localparam int ERASE = 200;
    localparam int BUSY  = 120;
    localparam int HP    = 8;
    localparam logic [15:0] MASK = 16'h0FFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_en = 1'b0;
    logic verify_en = 1'b0;
    logic pclk = 1'b0;
    logic pdat = 1'b0;
    logic pdat_out, pdat_oe, overflow;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int t_fall = 0;
    bit host_drv = 1'b0;
    bit done = 1'b0;
    int exp_mem [WORDS];
    int wr_ptr = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serprog_target #(
        .WORDS(WORDS), .W(W), .CFG_MASK(MASK), .ERASE_CYC(ERASE), .BUSY_CYC(BUSY)
    ) u_serprog_target (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .verify_en(verify_en),
        .pclk_in(pclk), .pdat_in(pdat), .pdat_out(pdat_out), .pdat_oe(pdat_oe),
        .overflow(overflow)
    );

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // every clock: block must never drive while the host is shifting data (R6/R7 release)
    always @(negedge clk) begin
        if (rst_n && host_drv) chk("R6 no drive while host shifts", int'(pdat_oe), 0);
    end

    task automatic send_word(input logic [15:0] w);
        host_drv = 1'b1;
        for (int b = 0; b < W; b++) begin
            @(negedge clk);
            pdat = w[b];
            pclk = 1'b1;
            wait_cyc(HP);
            pclk = 1'b0;
            t_fall = cyc;
            wait_cyc(HP);
        end
        host_drv = 1'b0;
    endtask

    // reference model: store a word at the next address
    task automatic model_write(input logic [15:0] w);
        if (wr_ptr < WORDS) begin
            exp_mem[wr_ptr] = (wr_ptr == WORDS - 1) ? int'(w & MASK) : int'(w);
            wr_ptr++;
        end
    endtask

    task automatic write_poll(input logic [15:0] w);
        int lat;
        send_word(w);
        model_write(w);
        pclk = 1'b1;
        wait_cyc(6);
        chk("R6 busy poll drives low", int'({pdat_oe, pdat_out}), 2);
        lat = -1;
        for (int k = 0; k < 4 * BUSY; k++) begin
            @(negedge clk);
            if (pdat_oe && pdat_out) begin
                lat = cyc - t_fall;
                break;
            end
        end
        chk("R5 busy length lower bound", int'(lat >= BUSY), 1);
        chk("R5 busy length upper bound", int'(lat <= BUSY + 12), 1);
        wait_cyc(20);
        chk("R7 high held while clock high", int'({pdat_oe, pdat_out}), 3);
        pclk = 1'b0;
        wait_cyc(6);
        chk("R7 released after clock low", int'(pdat_oe), 0);
    endtask

    task automatic write_nopoll(input logic [15:0] w);
        send_word(w);
        model_write(w);
        wait_cyc(BUSY / 2);
        chk("R6 no drive with clock low in busy", int'(pdat_oe), 0);
        wait_cyc(BUSY);
        chk("R7 released when busy ends low", int'(pdat_oe), 0);
    endtask

    task automatic read_word(output logic [15:0] r);
        r = '0;
        for (int b = 0; b < W; b++) begin
            @(negedge clk);
            wait_cyc(HP);
            r[b] = pdat_out;
            if (!pdat_oe) r[b] = 1'bx;
            pclk = 1'b1;
            wait_cyc(HP);
            pclk = 1'b0;
        end
        wait_cyc(HP);
    endtask

    initial begin : watchdog
        wait_cyc(150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] r;
        for (int i = 0; i < WORDS; i++) exp_mem[i] = 0;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        chk("R1 reset oe", int'(pdat_oe), 0);
        chk("R1 reset overflow", int'(overflow), 0);

        // R10 verify of reset contents
        verify_en = 1'b1;
        prog_en = 1'b1;
        wait_cyc(6);
        read_word(r);
        chk("R1 reset store word0", int'(r), 0);
        prog_en = 1'b0;
        verify_en = 1'b0;
        wait_cyc(4);

        // R2 session with junk edges during erase
        prog_en = 1'b1;
        wait_cyc(2);
        send_word_junk: for (int j = 0; j < 3; j++) begin
            pdat = 1'b1;
            pclk = 1'b1;
            wait_cyc(HP);
            pclk = 1'b0;
            wait_cyc(HP);
        end
        wait_cyc(ERASE);
        wr_ptr = 0;
        for (int i = 0; i < WORDS; i++) begin
            logic [15:0] w;
            w = (i == WORDS - 1) ? 16'hFFFF : (16'hA5C0 ^ 16'(i * 16'h1357));
            if (i % 2 == 0) write_poll(w);
            else            write_nopoll(w);
        end
        chk("R9 no overflow yet", int'(overflow), 0);

        // R9 overflow word
        send_word(16'h1234);
        wait_cyc(10);
        chk("R9 overflow set", int'(overflow), 1);
        pclk = 1'b1;
        wait_cyc(10);
        chk("R9 no busy after overflow", int'(pdat_oe), 0);
        pclk = 1'b0;
        wait_cyc(BUSY);
        chk("R9 overflow sticky", int'(overflow), 1);
        prog_en = 1'b0;
        wait_cyc(2);
        chk("R12 overflow cleared", int'(overflow), 0);
        chk("R12 line released", int'(pdat_oe), 0);

        // R10 read-back, R3 R4 order, R8 mask, R11 past end
        verify_en = 1'b1;
        prog_en = 1'b1;
        wait_cyc(6);
        for (int i = 0; i < WORDS; i++) begin
            read_word(r);
            if (i == WORDS - 1) chk("R8 masked last word", int'(r), exp_mem[i]);
            else                chk("R10 R3 R4 read-back word", int'(r), exp_mem[i]);
        end
        read_word(r);
        chk("R11 past end reads zero", int'(r), 0);
        chk("R10 drives in verify", int'(pdat_oe), 1);
        prog_en = 1'b0;
        wait_cyc(2);
        chk("R12 release after verify", int'(pdat_oe), 0);
        verify_en = 1'b0;
        wait_cyc(4);

        // R2 second session erases unwritten words
        prog_en = 1'b1;
        for (int i = 0; i < WORDS; i++) exp_mem[i] = 0;
        wr_ptr = 0;
        wait_cyc(ERASE + 10);
        write_nopoll(16'h0F0F);
        write_poll(16'h8001);
        prog_en = 1'b0;
        wait_cyc(4);
        verify_en = 1'b1;
        prog_en = 1'b1;
        wait_cyc(6);
        for (int i = 0; i < WORDS; i++) begin
            read_word(r);
            chk("R2 erase then rewrite", int'(r), exp_mem[i]);
        end
        prog_en = 1'b0;
        verify_en = 1'b0;
        wait_cyc(4);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule